// File: doc/BRIEF.md
# Least-Recently-Fetched Strand Fetch Arbiter

This block decides, cycle by cycle, which hardware strand of a multithreaded core may fetch one instruction. The core's eight strands are split into two fixed groups of four, each group feeding its own execution pipe. Every group has a private arbiter, and the two arbiters share no state, so traffic in one group never affects the other.

Inside a group the arbiter keeps a recency list of the four strands. Among the strands that are ready in a cycle, the one whose last grant lies furthest in the past wins. The granted strand then moves to the most-recent end of the list, and the others keep their relative order. A strand that requests rarely therefore wins every collision against strands that request every cycle.

The ready vector is a plain per-strand request that arrives already computed. The grant is a single-cycle decision with no back-pressure path. A grant is taken as consumed in the cycle it is shown, and the fetch path must accept it. A strand that is not granted simply keeps its ready bit high in the next cycle.

Top module: `lrf_fetch_arb`

## Requirements
- R1: Strands 0–3 form group 0 and strands 4–7 form group 1. The grants and recency state of one group do not depend on the ready bits of the other group.
- R2: In each group, at most one grant bit is high per cycle, and a grant bit is high only for a strand whose ready bit is high.
- R3: When several strands of a group are ready, the grant goes to the ready strand whose most recent grant is oldest.
- R4: A strand that is the only ready strand of its group is granted in every cycle that this holds.
- R5: If strand A is ready every cycle and strand B of the same group is ready once every five cycles, B is granted in each of those cycles and A receives four grants in every five cycles.
- R6: When all four strands of a group are ready every cycle, each of them receives exactly one grant in every four consecutive cycles.
- R7: After reset, the recency order in each group runs from the lowest-numbered strand (oldest) to the highest-numbered strand (newest).
- R8: When no strand of a group is ready, that group's valid bit is low, its grant bits are all zero, and its recency order is unchanged.
- R9: Grant and valid follow the current ready vector and recency state within the same cycle. The recency state updates only on the rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_rdy_i | input | 8 | Per-strand fetch request; bit i belongs to strand i |
| grant_o | output | 8 | One-hot-per-group fetch grant; bit i grants strand i |
| grant_vld_o | output | 2 | Bit g is high when group g grants a strand this cycle |

## Verification
The assertions take for granted that the ready vector is stable and known at each rising edge, and that it is held low while reset is asserted. The `$past`-based checks therefore never compare against values from before reset. The bench drives the ready vector only on falling edges and keeps it at zero through every reset pulse. The one scenario that changes the ready vector twice within a cycle does so well before the next rising edge, so the arbiter still sees a settled value at the edge.

// File: rtl/lrf_fetch_pkg.sv
package lrf_fetch_pkg;
  parameter int unsigned DEF_NUM_GROUPS = 2;
  parameter int unsigned DEF_GROUP_SIZE = 4;
endpackage

// File: rtl/lrf_pick.sv
// Scans the recency list from oldest to newest and picks the first ready strand.
module lrf_pick #(
  parameter int unsigned GS = 4,
  localparam int unsigned IW = $clog2(GS)
) (
  input  logic [GS-1:0]         rdy,
  input  logic [GS-1:0][IW-1:0] order,
  output logic [GS-1:0]         gnt,
  output logic                  vld,
  output logic [IW-1:0]         pos
);
  always_comb begin
    gnt = '0;
    vld = 1'b0;
    pos = '0;
    for (int p = 0; p < GS; p++) begin
      if (!vld && rdy[order[p]]) begin
        vld = 1'b1;
        pos = IW'(p);
        gnt[order[p]] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/lrf_reorder.sv
// Moves the picked entry to the newest slot; entries behind it shift toward the oldest end.
module lrf_reorder #(
  parameter int unsigned GS = 4,
  localparam int unsigned IW = $clog2(GS)
) (
  input  logic [GS-1:0][IW-1:0] order,
  input  logic                  vld,
  input  logic [IW-1:0]         pos,
  output logic [GS-1:0][IW-1:0] order_nxt
);
  always_comb begin
    order_nxt = order;
    if (vld) begin
      for (int p = 0; p < GS - 1; p++) begin
        if (p >= int'(pos)) order_nxt[p] = order[p+1];
      end
      order_nxt[GS-1] = order[pos];
    end
  end
endmodule

// File: rtl/lrf_group_arb.sv
module lrf_group_arb #(
  parameter int unsigned GS = 4,
  localparam int unsigned IW = $clog2(GS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [GS-1:0] rdy,
  output logic [GS-1:0] gnt,
  output logic          vld
);
  logic [GS-1:0][IW-1:0] order_q;
  logic [GS-1:0][IW-1:0] order_d;
  logic [IW-1:0]         pick_pos;

  lrf_pick #(.GS(GS)) u_pick (
    .rdy   (rdy),
    .order (order_q),
    .gnt   (gnt),
    .vld   (vld),
    .pos   (pick_pos)
  );

  lrf_reorder #(.GS(GS)) u_reorder (
    .order     (order_q),
    .vld       (vld),
    .pos       (pick_pos),
    .order_nxt (order_d)
  );

  // R7: oldest-to-newest follows strand numbering after reset
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int p = 0; p < GS; p++) order_q[p] <= IW'(p);
    end else begin
      order_q <= order_d;
    end
  end

  // Checker-side helpers
  logic [GS-1:0] seen;
  logic [GS-1:0] newest_oh;
  always_comb begin
    seen = '0;
    for (int p = 0; p < GS; p++) seen[order_q[p]] = 1'b1;
    newest_oh = '0;
    newest_oh[order_q[GS-1]] = 1'b1;
  end

  p_onehot_grant_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt));
  p_grant_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt & ~rdy) == '0);
  p_valid_any_r8: assert property (@(posedge clk) disable iff (!rst_n)
    vld == (|rdy));
  p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !vld |=> $stable(order_q));
  p_perm_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(seen) == GS);
  p_sole_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(rdy) == 1) |-> (gnt == rdy));
  p_newest_r3: assert property (@(posedge clk) disable iff (!rst_n)
    vld |=> (newest_oh == $past(gnt)));
endmodule

// File: rtl/lrf_fetch_arb.sv
module lrf_fetch_arb #(
  parameter int unsigned NUM_GROUPS = lrf_fetch_pkg::DEF_NUM_GROUPS,
  parameter int unsigned GROUP_SIZE = lrf_fetch_pkg::DEF_GROUP_SIZE,
  localparam int unsigned NUM_STRANDS = NUM_GROUPS * GROUP_SIZE
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NUM_STRANDS-1:0] fetch_rdy_i,
  output logic [NUM_STRANDS-1:0] grant_o,
  output logic [NUM_GROUPS-1:0]  grant_vld_o
);
  // R1: each group is a separate instance with no shared state
  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    lrf_group_arb #(.GS(GROUP_SIZE)) u_grp (
      .clk   (clk),
      .rst_n (rst_n),
      .rdy   (fetch_rdy_i[g*GROUP_SIZE +: GROUP_SIZE]),
      .gnt   (grant_o[g*GROUP_SIZE +: GROUP_SIZE]),
      .vld   (grant_vld_o[g])
    );
  end
endmodule

// File: tb/test_lrf_fetch_arb.sv
module test_lrf_fetch_arb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] rdy = '0;
  logic [7:0] gnt;
  logic [1:0] vld;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  lrf_fetch_arb i_lrf_fetch_arb (
    .clk(clk), .rst_n(rst_n), .fetch_rdy_i(rdy), .grant_o(gnt), .grant_vld_o(vld)
  );

  function automatic void chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endfunction

  function automatic logic [1:0] vexp(input logic [7:0] r);
    return {|r[7:4], |r[3:0]};
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; rdy = '0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  // One cycle: drive at the falling edge, sample 1 ns later
  task automatic cyc(input logic [7:0] r, input logic [7:0] eg, input string req);
    @(negedge clk);
    rdy = r;
    #1;
    chk(req, 32'(gnt), 32'(eg));
    chk(req, 32'(vld), 32'(vexp(r)));
  endtask

  task automatic t_reset_state();
    do_reset();
    cyc(8'h00, 8'h00, "R8 reset idle");
  endtask

  task automatic t_reset_order();  // R7, R6
    do_reset();
    for (int k = 0; k < 8; k++) cyc(8'h0F, 8'(1 << (k % 4)), "R7/R6 round order");
  endtask

  task automatic t_oldest();  // R3
    do_reset();
    cyc(8'h04, 8'h04, "R3 prime strand2");
    cyc(8'h06, 8'h02, "R3 strand1 older");
    cyc(8'h0C, 8'h08, "R3 strand3 older");
  endtask

  task automatic t_sole();  // R4
    do_reset();
    for (int k = 0; k < 5; k++) cyc(8'h08, 8'h08, "R4 sole requester");
    for (int k = 0; k < 3; k++) cyc(8'h20, 8'h20, "R4 sole requester grp1");
  endtask

  task automatic t_ratio();  // R5
    int a_cnt = 0;
    do_reset();
    for (int k = 0; k < 20; k++) begin
      logic coll;
      coll = (k % 5 == 4);
      cyc(coll ? 8'h06 : 8'h02, coll ? 8'h04 : 8'h02, "R5 rare strand wins");
      if (gnt[1]) a_cnt++;
    end
    chk("R5 frequent gets 4 of 5", 32'(a_cnt), 32'd16);
  endtask

  task automatic t_idle_hold();  // R8
    do_reset();
    cyc(8'h0F, 8'h01, "R8 before idle");
    for (int k = 0; k < 3; k++) cyc(8'h00, 8'h00, "R8 idle");
    cyc(8'h0F, 8'h02, "R8 order kept over idle");
  endtask

  task automatic t_independent();  // R1
    int g1 [8] = '{6, 4, 6, 5, 6, 7, 6, 4};
    do_reset();
    for (int k = 0; k < 8; k++) begin
      logic [7:0] r;
      r = 8'h0F | ((k % 2 == 1) ? 8'hF0 : 8'h40);
      cyc(r, 8'(1 << (k % 4)) | 8'(1 << g1[k]), "R1 groups independent");
    end
  endtask

  task automatic t_comb();  // R9
    do_reset();
    @(negedge clk);
    rdy = 8'h01;
    #1 chk("R9 same-cycle grant a", 32'(gnt), 32'h01);
    rdy = 8'h02;
    #1 chk("R9 same-cycle grant b", 32'(gnt), 32'h02);
    cyc(8'h0F, 8'h01, "R9 update at edge only");
  endtask

  initial begin
    t_reset_state();
    t_reset_order();
    t_oldest();
    t_sole();
    t_ratio();
    t_idle_hold();
    t_independent();
    t_comb();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule